// File: doc/BRIEF.md
# UART Receiver Mute and Wakeup Controller

This block sits next to a UART receiver and decides whether each completed frame is announced to the host or silently dropped. Software can put the receiver into a muted state. While muted, finished frames do not raise the receive-data-ready strobe. The block leaves the muted state in one of two ways, chosen by a wakeup-method input.

In idle-line wakeup, an idle line seen by the receiver ends the mute. In address-mark wakeup, the top data bit of each frame tells an address frame from a data frame. The low bits of an address frame are compared with the node address of this receiver. A matching address frame ends the mute, and that frame is delivered. A non-matching address frame mutes the receiver, even if it was not muted before.

The compare covers either the lowest four bits or every data bit below the address flag. The position of that flag depends on the word length and on whether a parity bit is in use.

Top module: `uart_mute_wake`

## Requirements
- R1: After reset, mute_o is 0 and rx_ready_o is 0.
- R2: A mute_req_i pulse while rx_busy_i is 0 sets mute_o from the next clock edge on.
- R3: A mute_req_i pulse while rx_busy_i is 1 is dropped, and mute_o stays 0.
- R4: While mute_o is 1, frame_done_i produces no rx_ready_o pulse. This holds for every frame in idle-line wakeup, and for data frames and non-matching address frames in address-mark wakeup.
- R5: While mute_o is 0, a frame_done_i that is not a non-matching address frame in address-mark wakeup produces a one-cycle rx_ready_o pulse one clock later.
- R6: With wake_sel_i=0 (idle-line wakeup), idle_det_i while muted clears mute_o one clock later. Frames after that are delivered.
- R7: With wake_sel_i=1 (address-mark wakeup), idle_det_i has no effect on mute_o.
- R8: The address flag is bit K of rx_data_i, with K = 7 + word9_i - parity_en_i. Here word9_i=0 selects 8 data bits and word9_i=1 selects 9. A frame with bit K set is an address frame; a frame with bit K clear is a data frame.
- R9: With addr_wide_i=0, only rx_data_i[3:0] is compared with node_addr_i[3:0]. Bits above these do not affect the match.
- R10: With addr_wide_i=1, the bits rx_data_i[K-1:0] are compared with node_addr_i[K-1:0].
- R11: In address-mark wakeup, a matching address frame clears mute_o and is delivered with an rx_ready_o pulse.
- R12: In address-mark wakeup, a non-matching address frame sets mute_o and is not delivered, whether or not the receiver was muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_busy_i | input | 1 | Receiver is in the middle of a frame |
| frame_done_i | input | 1 | One-cycle strobe when a frame is complete |
| rx_data_i | input | 9 | Received word, including the parity bit when parity is on |
| parity_en_i | input | 1 | The top bit of the word is a parity bit |
| word9_i | input | 1 | 0: 8-bit word, 1: 9-bit word |
| idle_det_i | input | 1 | Idle line detected strobe |
| wake_sel_i | input | 1 | 0: idle-line wakeup, 1: address-mark wakeup |
| node_addr_i | input | 8 | Node address of this receiver |
| addr_wide_i | input | 1 | 0: 4-bit compare, 1: compare all bits below the flag |
| mute_req_i | input | 1 | Software request to enter mute |
| mute_o | output | 1 | Mute status |
| rx_ready_o | output | 1 | Gated receive-buffer-full pulse |

## Verification
The assertions assume that frame_done_i is a single-cycle strobe that arrives while rx_busy_i is low. They also assume that the configuration inputs (word length, parity, wakeup method, address width and node address) do not change in the cycle in which a frame completes. The stimulus changes the configuration only between frames, on the falling clock edge. It never raises frame_done_i, idle_det_i and mute_req_i in the same cycle, so each check sees one cause at a time.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_e;

  localparam int unsigned BASE_W = 8;
  localparam int unsigned NARROW_W = 4;
endpackage

// File: rtl/uart_addr_match.sv
module uart_addr_match #(
  parameter int unsigned DATA_W   = 9,
  parameter int unsigned ADDR_W   = DATA_W - 1,
  parameter int unsigned NARROW_W = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              parity_en_i,
  input  logic              word_long_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              wide_i,
  output logic              is_addr_o,
  output logic              hit_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  flag_idx;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] diff;

  // flag sits just below the parity bit of the selected word
  always_comb begin
    flag_idx = IDX_W'(DATA_W - 2);
    if (word_long_i) flag_idx = flag_idx + IDX_W'(1);
    if (parity_en_i) flag_idx = flag_idx - IDX_W'(1);
  end

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) begin
      if (wide_i) mask[i] = (i < int'(flag_idx));
      else        mask[i] = (i < NARROW_W);
    end
  end

  assign diff      = (data_i[ADDR_W-1:0] ^ node_addr_i) & mask;
  assign hit_o     = (diff == '0);
  assign is_addr_o = data_i[flag_idx];
endmodule

// File: rtl/uart_mute_ctrl.sv
module uart_mute_ctrl
  import uart_mute_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_busy_i,
  input  logic  frame_done_i,
  input  logic  idle_det_i,
  input  wake_e wake_i,
  input  logic  mute_req_i,
  input  logic  is_addr_i,
  input  logic  hit_i,
  output logic  mute_o,
  output logic  rx_ready_o
);
  logic mute_q, mute_d;
  logic ready_q, deliver;
  logic addr_frame;
  logic req_ok;

  assign addr_frame = frame_done_i && (wake_i == WAKE_ADDR) && is_addr_i;
  assign req_ok     = mute_req_i && !rx_busy_i;

  always_comb begin
    if (addr_frame) deliver = hit_i;
    else            deliver = frame_done_i && !mute_q;
  end

  // priority: frame end, then software request, then idle wake
  always_comb begin
    mute_d = mute_q;
    if (frame_done_i) begin
      if (addr_frame) mute_d = !hit_i;
    end else if (req_ok) begin
      mute_d = 1'b1;
    end else if (idle_det_i && (wake_i == WAKE_IDLE)) begin
      mute_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      mute_q  <= mute_d;
      ready_q <= deliver;
    end
  end

  assign mute_o     = mute_q;
  assign rx_ready_o = ready_q;

  p_req_sets_mute_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_req_i && !rx_busy_i && !frame_done_i) |=> mute_o);

  p_busy_req_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_o && mute_req_i && rx_busy_i && !frame_done_i) |=> !mute_o);

  p_muted_no_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && frame_done_i && !(addr_frame && hit_i)) |=> !rx_ready_o);

  p_idle_wakes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && idle_det_i && wake_i == WAKE_IDLE && !frame_done_i && !mute_req_i)
    |=> !mute_o);

  p_idle_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_det_i && wake_i == WAKE_ADDR && !frame_done_i && !mute_req_i)
    |=> $stable(mute_o));

  p_match_delivers_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_frame && hit_i) |=> (rx_ready_o && !mute_o));

  p_miss_mutes_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_frame && !hit_i) |=> (mute_o && !rx_ready_o));

  p_ready_needs_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> $past(frame_done_i));
endmodule

// File: rtl/uart_mute_wake.sv
module uart_mute_wake
  import uart_mute_pkg::*;
#(
  parameter int unsigned DATA_W = BASE_W + 1,
  parameter int unsigned ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_busy_i,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              parity_en_i,
  input  logic              word9_i,
  input  logic              idle_det_i,
  input  logic              wake_sel_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic              addr_wide_i,
  input  logic              mute_req_i,
  output logic              mute_o,
  output logic              rx_ready_o
);
  logic is_addr, hit;

  uart_addr_match #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NARROW_W(NARROW_W)
  ) u_match (
    .data_i     (rx_data_i),
    .parity_en_i(parity_en_i),
    .word_long_i(word9_i),
    .node_addr_i(node_addr_i),
    .wide_i     (addr_wide_i),
    .is_addr_o  (is_addr),
    .hit_o      (hit)
  );

  uart_mute_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_busy_i   (rx_busy_i),
    .frame_done_i(frame_done_i),
    .idle_det_i  (idle_det_i),
    .wake_i      (wake_e'(wake_sel_i)),
    .mute_req_i  (mute_req_i),
    .is_addr_i   (is_addr),
    .hit_i       (hit),
    .mute_o      (mute_o),
    .rx_ready_o  (rx_ready_o)
  );
endmodule

// File: tb/uart_mute_wake_tb.sv
module uart_mute_wake_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy = 1'b0, done = 1'b0, par = 1'b0, w9 = 1'b0, idle = 1'b0;
  logic wsel = 1'b0, wide = 1'b0, req = 1'b0;
  logic [8:0] data = '0;
  logic [7:0] node = '0;
  logic mute, rdy;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  uart_mute_wake dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_busy_i(busy), .frame_done_i(done),
    .rx_data_i(data), .parity_en_i(par), .word9_i(w9), .idle_det_i(idle),
    .wake_sel_i(wsel), .node_addr_i(node), .addr_wide_i(wide),
    .mute_req_i(req), .mute_o(mute), .rx_ready_o(rdy)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // frame_done for one cycle; outputs observed after the capturing edge
  task automatic frame(input logic [8:0] d, input logic exp_rdy, input logic exp_mute,
                       input string tag);
    @(negedge clk); data = d; done = 1'b1;
    @(negedge clk); done = 1'b0;
    check({tag, " ready"}, rdy, exp_rdy);
    check({tag, " mute"}, mute, exp_mute);
    @(negedge clk);
    check({tag, " pulse ends"}, rdy, 1'b0);
  endtask

  task automatic pulse_req(input logic b);
    @(negedge clk); busy = b; req = 1'b1;
    @(negedge clk); req = 1'b0; busy = 1'b0;
  endtask

  task automatic pulse_idle();
    @(negedge clk); idle = 1'b1;
    @(negedge clk); idle = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 mute after reset", mute, 1'b0);
    check("R1 ready after reset", rdy, 1'b0);
  endtask

  task automatic t_idle_mode();
    wsel = 1'b0;
    frame(9'h041, 1'b1, 1'b0, "R5 unmuted frame");
    pulse_req(1'b0);
    check("R2 request mutes", mute, 1'b1);
    frame(9'h042, 1'b0, 1'b1, "R4 muted frame idle mode");
    frame(9'h1FF, 1'b0, 1'b1, "R4 muted frame flag set idle mode");
    pulse_idle();
    check("R6 idle clears mute", mute, 1'b0);
    frame(9'h043, 1'b1, 1'b0, "R6 frame after wake");
  endtask

  task automatic t_busy_req();
    pulse_req(1'b1);
    check("R3 busy request ignored", mute, 1'b0);
    frame(9'h044, 1'b1, 1'b0, "R3 still delivering");
  endtask

  task automatic t_narrow();
    wsel = 1'b1; wide = 1'b0; w9 = 1'b0; par = 1'b0; node = 8'h25;
    frame(9'h086, 1'b0, 1'b1, "R12 miss while unmuted");
    pulse_idle();
    check("R7 idle ignored in address mode", mute, 1'b1);
    frame(9'h005, 1'b0, 1'b1, "R4 data frame muted");
    frame(9'h085, 1'b1, 1'b0, "R11 R9 match");
    frame(9'h010, 1'b1, 1'b0, "R5 data after match");
    frame(9'h086, 1'b0, 1'b1, "R12 miss remutes");
    frame(9'h0F5, 1'b1, 1'b0, "R9 upper bits ignored");
  endtask

  task automatic t_wide();
    wsel = 1'b1; wide = 1'b1;
    w9 = 1'b1; par = 1'b0; node = 8'hA5;
    frame(9'h1B5, 1'b0, 1'b1, "R10 9bit mismatch bit4");
    frame(9'h0A5, 1'b0, 1'b1, "R8 9bit flag bit8 clear is data");
    frame(9'h1A5, 1'b1, 1'b0, "R10 R8 9bit match");
    w9 = 1'b1; par = 1'b1; node = 8'h25;
    frame(9'h1A5, 1'b1, 1'b0, "R8 9bit parity flag bit7 match");
    frame(9'h0E5, 1'b0, 1'b1, "R10 bit6 compared");
    w9 = 1'b0; par = 1'b1; node = 8'h15;
    frame(9'h015, 1'b0, 1'b1, "R8 8bit parity data frame muted");
    frame(9'h0D5, 1'b1, 1'b0, "R8 R10 8bit parity flag bit6 match");
    w9 = 1'b0; par = 1'b0; node = 8'h15;
    frame(9'h0D5, 1'b0, 1'b1, "R10 8bit bit6 in compare");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_mode();
    t_busy_req();
    t_narrow();
    t_wide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule